// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the arithmetic and logic unit of a small 64-bit integer core. It combines two operands, `op_a` and `op_b`, with one of four functions (add, subtract, bitwise and, bitwise exclusive or). The result is available in the same cycle. Subtraction takes the first operand away from the second, so the result is `op_b - op_a`, the order a two-register subtract instruction uses when it writes the difference back over its second register.

When `cc_we` is high at a rising clock edge, three condition flags are captured from the current operation: zero, sign and signed overflow. When `cc_we` is low the flags hold their value. A condition evaluator reads the stored flags and a 4-bit selector and drives one bit, `cond`. That bit gates conditional moves and branches. The signed less-than and greater-than tests use sign xor overflow, so they stay correct when the subtraction wraps. The width is a parameter, so an 8-bit copy can be checked over every operand pair.

Top module: `alu_ccu`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `op_a + op_b` modulo 2^WIDTH, combinationally.
- R2: With `alu_fn` = 1, `result` equals `op_b - op_a` modulo 2^WIDTH. In 8 bits, 0x7D - 0xBD gives 0xC0 and 0x7D - 0x3D gives 0x40.
- R3: With `alu_fn` = 2, `result` is `op_a & op_b`. With `alu_fn` = 3, it is `op_a ^ op_b`.
- R4: At a rising edge with `cc_we` high, `zf_q` becomes 1 exactly when `result` is all zeros, and `sf_q` becomes the most significant bit of `result`.
- R5: For add, `of_q` is set when both operands have the same sign bit and the result's sign bit differs from it. In 8 bits, 0xCD + 0x87 overflows and 0x73 + 0xB0 does not.
- R6: For subtract, `of_q` is set when the operands' sign bits differ and the result's sign bit differs from that of `op_b`. For and and xor, `of_q` is cleared.
- R7: At an edge with `cc_we` low, all three flags keep their value.
- R8: `cond` is set by `cond_fn` as follows. 0 gives 1. 1 gives (SF^OF)|ZF. 2 gives SF^OF. 3 gives ZF. 4 gives !ZF. 5 gives !(SF^OF). 6 gives !(SF^OF)&!ZF.
- R9: For `cond_fn` values 7 to 15, `cond` is 0.
- R10: During and after reset (`rst_n` low, active low, asynchronous), the flags are ZF=1, SF=0 and OF=0.
- R11: `cond` reflects only the stored flags. An update takes effect on `cond` in the cycle after the enabling edge, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | WIDTH | First operand (subtrahend for subtract) |
| op_b | input | WIDTH | Second operand (minuend for subtract) |
| alu_fn | input | 2 | 0 add, 1 subtract, 2 and, 3 xor |
| cc_we | input | 1 | Capture flags from this operation |
| cond_fn | input | 4 | Condition selector |
| result | output | WIDTH | Combinational ALU result |
| zf_q | output | 1 | Stored zero flag |
| sf_q | output | 1 | Stored sign flag |
| of_q | output | 1 | Stored signed overflow flag |
| cond | output | 1 | Evaluated condition |

All ports are plain signals. Operands are taken every cycle and the result is combinational, so there is no stream handshake and no back-pressure.

## Verification
A flag update and a condition evaluation can fall in the same cycle. This is what happens when an instruction that sets the flags sits directly in front of a conditional branch that reads them. The bench provokes this case by driving an operation with `cc_we` high together with a new `cond_fn`. Just before the edge, `cond` must still follow the old flags. After the edge, it must follow the new ones. Operand sequences from signed arithmetic examples show whether the flags and conditions come out right: wrap-around in both directions, the ordering 8 vs 3 and 3 vs 8, and a counter decremented down to zero.

// File: rtl/alu_ccu_pkg.sv
package alu_ccu_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_op_e;

  // Condition selector; codes above CND_GT evaluate false.
  typedef enum logic [3:0] {
    CND_ALWAYS = 4'd0,
    CND_LE     = 4'd1,
    CND_LT     = 4'd2,
    CND_EQ     = 4'd3,
    CND_NE     = 4'd4,
    CND_GE     = 4'd5,
    CND_GT     = 4'd6
  } cnd_sel_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } ccodes_t;

  localparam ccodes_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_ccu_core.sv
module alu_ccu_core
  import alu_ccu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] r,
  output ccodes_t          cc_next
);
  localparam int MSB = WIDTH - 1;

  logic ovf;

  always_comb begin
    r   = '0;
    ovf = 1'b0;
    unique case (op)
      ALU_ADD: begin
        r   = b + a;
        ovf = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
      end
      ALU_SUB: begin
        r   = b - a;
        // b + (-a): signs of b and -a agree when a and b differ.
        ovf = (a[MSB] != b[MSB]) && (r[MSB] != b[MSB]);
      end
      ALU_AND: r = a & b;
      ALU_XOR: r = a ^ b;
      default: r = '0;
    endcase
  end

  assign cc_next.zf = (r == '0);
  assign cc_next.sf = r[MSB];
  assign cc_next.of = ovf;

endmodule

// File: rtl/alu_ccu_flags.sv
module alu_ccu_flags
  import alu_ccu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  ccodes_t d,
  output ccodes_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CC_RESET;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu_ccu_cond.sv
module alu_ccu_cond
  import alu_ccu_pkg::*;
(
  input  ccodes_t    cc,
  input  logic [3:0] sel,
  output logic       hit
);
  logic lt;
  assign lt = cc.sf ^ cc.of;

  always_comb begin
    case (sel)
      CND_ALWAYS: hit = 1'b1;
      CND_LE:     hit = lt | cc.zf;
      CND_LT:     hit = lt;
      CND_EQ:     hit = cc.zf;
      CND_NE:     hit = ~cc.zf;
      CND_GE:     hit = ~lt;
      CND_GT:     hit = ~lt & ~cc.zf;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_ccu.sv
module alu_ccu
  import alu_ccu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       alu_fn,
  input  logic             cc_we,
  input  logic [3:0]       cond_fn,
  output logic [WIDTH-1:0] result,
  output logic             zf_q,
  output logic             sf_q,
  output logic             of_q,
  output logic             cond
);
  ccodes_t cc_d, cc_q;
  alu_op_e op;

  assign op = alu_op_e'(alu_fn);

  alu_ccu_core #(.WIDTH(WIDTH)) u_core (
    .a       (op_a),
    .b       (op_b),
    .op      (op),
    .r       (result),
    .cc_next (cc_d)
  );

  alu_ccu_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cc_we),
    .d     (cc_d),
    .q     (cc_q)
  );

  alu_ccu_cond u_cond (
    .cc  (cc_q),
    .sel (cond_fn),
    .hit (cond)
  );

  assign zf_q = cc_q.zf;
  assign sf_q = cc_q.sf;
  assign of_q = cc_q.of;

endmodule

// File: rtl/alu_ccu_chk.sv
module alu_ccu_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       alu_fn,
  input logic             cc_we,
  input logic [3:0]       cond_fn,
  input logic [WIDTH-1:0] result,
  input logic             zf_q,
  input logic             sf_q,
  input logic             of_q,
  input logic             cond
);
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |=> zf_q == ($past(result) == '0));

  p_sign_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |=> sf_q == $past(result[WIDTH-1]));

  p_logic_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && alu_fn[1]) |=> !of_q);

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_we |=> $stable({zf_q, sf_q, of_q}));

  p_cond_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn == 4'd0) |-> cond);

  p_cond_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn == 4'd3) |-> (cond == zf_q));

  p_cond_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn > 4'd6) |-> !cond);

  p_reset_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (zf_q && !sf_q && !of_q));
endmodule

bind alu_ccu alu_ccu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .alu_fn  (alu_fn),
  .cc_we   (cc_we),
  .cond_fn (cond_fn),
  .result  (result),
  .zf_q    (zf_q),
  .sf_q    (sf_q),
  .of_q    (of_q),
  .cond    (cond)
);

// File: tb/alu_ccu_test.sv
`timescale 1ns/1ps
module alu_ccu_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0]   alu_fn = 2'd0;
  logic         cc_we = 1'b0;
  logic [3:0]   cond_fn = 4'd0;
  logic [W-1:0] result;
  logic         zf_q, sf_q, of_q, cond;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  alu_ccu #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .cc_we(cc_we), .cond_fn(cond_fn), .result(result),
    .zf_q(zf_q), .sf_q(sf_q), .of_q(of_q), .cond(cond)
  );

  // Reference model
  function automatic logic [W-1:0] m_res(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    case (f)
      2'd0: return b + a;
      2'd1: return b - a;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic m_ovf(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    int sa, sb, s;
    sa = $signed(a); sb = $signed(b);
    if (f == 2'd0) s = sb + sa;
    else if (f == 2'd1) s = sb - sa;
    else return 1'b0;
    return (s > 127) || (s < -128);
  endfunction

  function automatic logic m_cond(logic z, logic s, logic o, logic [3:0] f);
    case (f)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply one flag-setting operation; returns after the capturing edge.
  task automatic do_op(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    @(negedge clk);
    op_a = a; op_b = b; alu_fn = f; cc_we = 1'b1;
    @(negedge clk);
    cc_we = 1'b0;
  endtask

  task automatic chk_flags(string req, logic z, logic s, logic o);
    chk(req, {61'd0, zf_q, sf_q, of_q}, {61'd0, z, s, o});
  endtask

  task automatic chk_cond(string req, logic [3:0] f, logic exp);
    cond_fn = f; #0.5;
    chk(req, {63'd0, cond}, {63'd0, exp});
  endtask

  task automatic t_reset();
    chk_flags("R10 reset flags", 1'b1, 1'b0, 1'b0);
    chk_cond("R10 eq after reset", 4'd3, 1'b1);
  endtask

  task automatic t_exhaustive();
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          op_a = W'(a); op_b = W'(b); alu_fn = 2'(f); #0.25;
          chk(f == 0 ? "R1 add" : f == 1 ? "R2 sub" : "R3 logic",
              {56'd0, result}, {56'd0, m_res(W'(a), W'(b), 2'(f))});
        end
  endtask

  task automatic t_flag_sweep();
    logic [W-1:0] r;
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 256; a += 17)
        for (int b = 0; b < 256; b += 13) begin
          do_op(W'(a), W'(b), 2'(f));
          r = m_res(W'(a), W'(b), 2'(f));
          chk_flags(f == 1 ? "R4 R6 sub flags" : f == 0 ? "R4 R5 add flags" : "R4 R6 logic flags",
                    r == '0, r[W-1], m_ovf(W'(a), W'(b), 2'(f)));
          for (int c = 0; c < 16; c++)
            chk_cond(c > 6 ? "R9 unused cond" : "R8 cond table", 4'(c),
                     m_cond(r == '0, r[W-1], m_ovf(W'(a), W'(b), 2'(f)), 4'(c)));
        end
  endtask

  task automatic t_examples();
    do_op(8'hB0, 8'h73, 2'd0);
    chk("R1 0x73+0xB0", {56'd0, result}, 64'h23);
    chk_flags("R5 no overflow", 1'b0, 1'b0, 1'b0);
    do_op(8'h87, 8'hCD, 2'd0);
    chk("R1 0xCD+0x87", {56'd0, result}, 64'h54);
    chk_flags("R5 negative overflow", 1'b0, 1'b0, 1'b1);
    chk_cond("R8 lt after neg ovf", 4'd2, 1'b1);
    do_op(8'hBD, 8'h7D, 2'd1);
    chk("R2 0x7D-0xBD", {56'd0, result}, 64'hC0);
    chk_flags("R6 positive overflow", 1'b0, 1'b1, 1'b1);
    chk_cond("R8 gt after pos ovf", 4'd6, 1'b1);
    do_op(8'h3D, 8'h7D, 2'd1);
    chk("R2 0x7D-0x3D", {56'd0, result}, 64'h40);
    chk_flags("R6 sub no overflow", 1'b0, 1'b0, 1'b0);
    do_op(8'd3, 8'd8, 2'd1);
    chk_cond("R8 8-3 not less", 4'd2, 1'b0);
    do_op(8'd8, 8'd3, 2'd1);
    chk("R2 3-8", {56'd0, result}, 64'hFB);
    chk_cond("R8 3-8 less", 4'd2, 1'b1);
    do_op(8'd8, 8'd13, 2'd1);
    chk_cond("R8 13-8 greater", 4'd6, 1'b1);
    chk_cond("R8 13-8 not le", 4'd1, 1'b0);
    do_op(8'hFF, 8'h0F, 2'd2);
    chk_flags("R6 and clears of", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_countdown();
    logic [W-1:0] cnt;
    cnt = 8'd4;
    for (int i = 0; i < 4; i++) begin
      do_op(8'hFF, cnt, 2'd0);
      cnt = cnt - 1;
      chk_cond("R8 ne countdown", 4'd4, cnt != 0);
    end
    chk_flags("R4 counter at zero", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    do_op(8'd8, 8'd3, 2'd1);          // negative, no overflow
    @(negedge clk);
    op_a = 8'd0; op_b = 8'd0; alu_fn = 2'd0; cc_we = 1'b0;
    repeat (3) @(negedge clk);
    chk_flags("R7 flags hold with zero result", 1'b0, 1'b1, 1'b0);
    chk_cond("R7 lt still set", 4'd2, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_op(8'd5, 8'd5, 2'd1);          // ZF=1
    @(negedge clk);
    op_a = 8'd1; op_b = 8'd9; alu_fn = 2'd1; cc_we = 1'b1; cond_fn = 4'd3;
    #1;
    chk("R11 old flags before edge", {63'd0, cond}, 64'd1);
    @(negedge clk);
    cc_we = 1'b0;
    chk("R11 new flags after edge", {63'd0, cond}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exhaustive();
    t_examples();
    t_countdown();
    t_hold();
    t_same_cycle();
    t_flag_sweep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule